// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block drives one always-running clock from one of several sources. Some sources are direct reference clocks. The last source is the output of a plain combinational auxiliary mux, which may glitch when its own select changes. Software writes a one-hot request. The selector then shuts the old source off on that source's own clock, waits until the gate is confirmed closed, and opens the new source on the new clock. Each gate only changes while its clock is low, so the output never shows a shortened high or low phase.

A one-hot status word tells software which source is driving the output. The status word reads all zeros while a handover is in progress, so software can poll it to see that a change is complete. A request that arrives during a handover waits until that handover is done and is then acted on. A request that is not one-hot is ignored. The auxiliary mux select may only change while the selector is parked on a different source. To retune the auxiliary source, software does the following:

1. Select a reference clock.
2. Poll the status until it shows that reference.
3. Change the auxiliary select.
4. Request the auxiliary input again.

Top module: `gcs_clock_switch`

## Requirements
- R1: After reset, the status word is 1 on bit 0 only (one-hot, bit i means source i), and the output follows reference 0.
- R2: The output never carries a high or low phase shorter than the shortest half period among the sources, and at most one source gate is open at any time.
- R3: The output is never stopped for longer than the time needed to close the old gate and open the new one. This is about three periods of the old clock, plus three of the new clock, plus two control cycles.
- R4: From the control cycle after a request is accepted, the status word reads all zeros until the new gate is open. It then reads one-hot with the requested bit set.
- R5: Once the status shows source i, the output follows source i edge for edge.
- R6: A request that changes during a handover does not disturb that handover. The most recent request is taken up after the status becomes non-zero again.
- R7: The auxiliary source is the highest index. It forwards auxiliary clock k when the auxiliary select equals k. Changing the auxiliary select while another source is selected has no effect on the output.
- R8: A request word with zero bits set or more than one bit set is ignored. The selection and the status stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk_i | input | 1 | Control clock for request capture and status |
| ctl_rst_ni | input | 1 | Active-low asynchronous reset, control domain |
| ref_clk_i | input | N_REF | Direct reference clock sources, index 0 upward |
| aux_clk_i | input | N_AUX | Candidate clocks for the auxiliary mux |
| aux_sel_i | input | AUX_SW | Auxiliary mux select (binary index) |
| src_rst_ni | input | N_REF+1 | Active-low asynchronous reset per source domain, auxiliary last |
| sel_req_i | input | N_REF+1 | One-hot source request |
| sel_status_o | output | N_REF+1 | One-hot source currently driving the output, zero during a handover |
| clk_o | output | 1 | Selected clock output |

## Verification
A handshake state that opens a gate too early shows up at once as a narrow pulse or an extra edge on the output. The bench catches this by timing every output phase. A gate that never reopens shows as an output gap longer than the handover bound, or as a status word that stays at zero. Each is visible within a few source periods. Wrong request handling surfaces in the order in which non-zero status values appear, and in whether the output follows the expected source edge for edge after each handover.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_pair_t;

    function automatic bit is_onehot(input logic [31:0] v, input int unsigned width);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned k = 0; k < 32; k++) begin
            if (k < width && v[k]) cnt++;
        end
        return cnt == 1;
    endfunction

endpackage

// File: rtl/gcs_aux_mux.sv
module gcs_aux_mux #(
    parameter int N_AUX  = 2,
    parameter int AUX_SW = 1
) (
    input  logic [N_AUX-1:0]  aux_clk_i,
    input  logic [AUX_SW-1:0] sel_i,
    output logic              clk_o
);

    always_comb begin
        clk_o = 1'b0;
        for (int k = 0; k < N_AUX; k++) begin
            if (sel_i == AUX_SW'(k)) clk_o = aux_clk_i[k];
        end
    end

endmodule

// File: rtl/gcs_src_gate.sv
module gcs_src_gate #(
    parameter bit RESET_ON = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic gate_o
);
    import gcs_pkg::*;

    sync_pair_t sync_d, sync_q;
    logic       gate_d, gate_q;

    always_comb begin
        sync_d.s1 = en_i;
        sync_d.s2 = sync_q.s1;
        gate_d    = sync_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '{s1: RESET_ON, s2: RESET_ON};
        else         sync_q <= sync_d;
    end

    // gate only moves while the source clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= RESET_ON;
        else         gate_q <= gate_d;
    end

    assign gate_o = gate_q;

    AST_GATE_FOLLOWS_SYNC: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (sync_q.s2 != gate_q) |=> (gate_q == $past(sync_q.s2))); // R2

endmodule

// File: rtl/gcs_sel_ctrl.sv
module gcs_sel_ctrl #(
    parameter int N_SRC = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] gate_i,
    output logic [N_SRC-1:0] target_o,
    output logic [N_SRC-1:0] status_o
);
    import gcs_pkg::*;

    localparam logic [N_SRC-1:0] RESET_VEC = N_SRC'(1);

    typedef struct packed {
        logic [N_SRC-1:0] s1;
        logic [N_SRC-1:0] s2;
        logic [N_SRC-1:0] tgt;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       req_ok;

    assign status_o = (st_q.s2 == st_q.tgt) ? st_q.tgt : '0;
    assign target_o = st_q.tgt;

    always_comb begin
        req_ok    = is_onehot(32'(req_i), N_SRC);
        st_d      = st_q;
        st_d.s1   = gate_i;
        st_d.s2   = st_q.s1;
        if (req_ok && (req_i != st_q.tgt) && (status_o != '0)) begin
            st_d.tgt = req_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{s1: RESET_VEC, s2: RESET_VEC, tgt: RESET_VEC};
        else         st_q <= st_d;
    end

    AST_TARGET_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(st_q.tgt)); // R6
    AST_HELD_IN_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == '0) |=> $stable(st_q.tgt)); // R6
    AST_BAD_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$onehot(req_i) |=> $stable(st_q.tgt)); // R8
    AST_STATUS_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(status_o)); // R4

endmodule

// File: rtl/gcs_clock_switch.sv
module gcs_clock_switch #(
    parameter int N_REF = 2,
    parameter int N_AUX = 2,
    localparam int N_SRC  = N_REF + 1,
    localparam int AUX_SW = (N_AUX > 1) ? $clog2(N_AUX) : 1
) (
    input  logic              ctl_clk_i,
    input  logic              ctl_rst_ni,
    input  logic [N_REF-1:0]  ref_clk_i,
    input  logic [N_AUX-1:0]  aux_clk_i,
    input  logic [AUX_SW-1:0] aux_sel_i,
    input  logic [N_SRC-1:0]  src_rst_ni,
    input  logic [N_SRC-1:0]  sel_req_i,
    output logic [N_SRC-1:0]  sel_status_o,
    output logic              clk_o
);

    localparam int AUX_IDX = N_SRC - 1;

    logic             aux_clk;
    logic [N_SRC-1:0] src_clk;
    logic [N_SRC-1:0] gate_vec;
    logic [N_SRC-1:0] en_vec;
    logic [N_SRC-1:0] target;

    gcs_aux_mux #(.N_AUX(N_AUX), .AUX_SW(AUX_SW)) u_aux_mux (
        .aux_clk_i (aux_clk_i),
        .sel_i     (aux_sel_i),
        .clk_o     (aux_clk)
    );

    assign src_clk = {aux_clk, ref_clk_i};

    gcs_sel_ctrl #(.N_SRC(N_SRC)) u_ctrl (
        .clk_i    (ctl_clk_i),
        .rst_ni   (ctl_rst_ni),
        .req_i    (sel_req_i),
        .gate_i   (gate_vec),
        .target_o (target),
        .status_o (sel_status_o)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic [N_SRC-1:0] others;
        assign others    = gate_vec & ~(N_SRC'(1) << i);
        assign en_vec[i] = target[i] & ~(|others);

        gcs_src_gate #(.RESET_ON(i == 0)) u_gate (
            .clk_i  (src_clk[i]),
            .rst_ni (src_rst_ni[i]),
            .en_i   (en_vec[i]),
            .gate_o (gate_vec[i])
        );
    end

    assign clk_o = |(gate_vec & src_clk);

    AST_GATES_EXCLUSIVE: assert property (@(posedge ctl_clk_i) disable iff (!ctl_rst_ni)
        $onehot0(gate_vec)); // R2
    AST_STATUS_MATCHES_GATE: assert property (@(posedge ctl_clk_i) disable iff (!ctl_rst_ni)
        (sel_status_o != '0) |-> (gate_vec == sel_status_o)); // R4
    AST_AUX_PARKED: assert property (@(posedge ctl_clk_i) disable iff (!ctl_rst_ni)
        !$stable(aux_sel_i) |-> ((sel_status_o != '0) && !sel_status_o[AUX_IDX])); // R7

endmodule

// File: tb/gcs_clock_switch_bench.sv
`timescale 1ns/1ps
module gcs_clock_switch_bench;

    localparam real MIN_HALF = 5.003;
    localparam real GAP_MAX  = 400.0;

    logic       ctl_clk = 0, ctl_rst_n = 0;
    logic [1:0] ref_clk = '0;
    logic [1:0] aux_clk = '0;
    logic [0:0] aux_sel = '0;
    logic [2:0] src_rst_n = '0;
    logic [2:0] sel_req = 3'b001;
    logic [2:0] sel_status;
    logic       clk_out;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [2:0] exp_q[$];
    logic [2:0] prev_status = 3'b001;
    bit   mon_en = 0;
    int   trk = 0;
    logic mon_clk;
    int   glitch_cnt = 0;
    real  last_edge = 0.0, max_gap = 0.0;

    always #10.0   ctl_clk    = ~ctl_clk;
    always #7.013  ref_clk[0] = ~ref_clk[0];
    always #13.007 ref_clk[1] = ~ref_clk[1];
    always #5.003  aux_clk[0] = ~aux_clk[0];
    always #17.011 aux_clk[1] = ~aux_clk[1];

    assign mon_clk = (trk == 0) ? ref_clk[0] : (trk == 1) ? ref_clk[1] :
                     (trk == 2) ? aux_clk[0] : aux_clk[1];

    gcs_clock_switch u_gcs_clock_switch (
        .ctl_clk_i    (ctl_clk),
        .ctl_rst_ni   (ctl_rst_n),
        .ref_clk_i    (ref_clk),
        .aux_clk_i    (aux_clk),
        .aux_sel_i    (aux_sel),
        .src_rst_ni   (src_rst_n),
        .sel_req_i    (sel_req),
        .sel_status_o (sel_status),
        .clk_o        (clk_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // phase width and gap monitor for R2/R3
    always @(clk_out) begin
        if (mon_en) begin
            if ($realtime - last_edge < MIN_HALF - 0.1) glitch_cnt++;
            if ($realtime - last_edge > max_gap) max_gap = $realtime - last_edge;
        end
        last_edge = $realtime;
    end

    // scoreboard monitor: each new non-zero status must match the queue front
    always @(negedge ctl_clk) begin
        if (mon_en) begin
            if (sel_status != 3'b000 && prev_status == 3'b000) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected completion", 32'(sel_status), 0);
                end else begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    chk(sel_status == e, "R4/R6 completed status", 32'(sel_status), 32'(e));
                end
            end
            prev_status = sel_status;
        end
    end

    task automatic request(input logic [2:0] sel);
        @(negedge ctl_clk);
        sel_req = sel;
        exp_q.push_back(sel);
    endtask

    task automatic wait_done(input string req);
        bit ok;
        ok = 0;
        for (int n = 0; n < 300; n++) begin
            @(negedge ctl_clk);
            #1;
            if (exp_q.size() == 0 && sel_status != 3'b000) begin
                ok = 1;
                break;
            end
        end
        chk(ok, req, 32'(sel_status), 32'(sel_req));
    endtask

    task automatic track(input int idx, input string req);
        trk = idx;
        #0.5;
        for (int n = 0; n < 3; n++) begin
            @(posedge mon_clk); #1;
            chk(clk_out == 1'b1, req, 32'(clk_out), 1);
            @(negedge mon_clk); #1;
            chk(clk_out == 1'b0, req, 32'(clk_out), 0);
        end
    endtask

    initial begin
        #200000.0;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #95.0;
        ctl_rst_n = 1;
        src_rst_n = '1;
        last_edge = $realtime;
        @(negedge ctl_clk); #1;
        chk(sel_status == 3'b001, "R1 reset status", 32'(sel_status), 1);
        mon_en = 1;
        track(0, "R1 follows ref0 after reset");

        // R4/R5: switch to reference 1
        request(3'b010);
        @(negedge ctl_clk); #1;
        chk(sel_status == 3'b000, "R4 status zero while switching", 32'(sel_status), 0);
        wait_done("R4 switch to ref1");
        track(1, "R5 follows ref1");

        // R7: auxiliary input, select 0
        request(3'b100);
        wait_done("R7 switch to aux");
        track(2, "R7 follows aux0");

        // R7: park on ref0, retune aux, verify no effect, switch back
        request(3'b001);
        wait_done("R5 park on ref0");
        @(negedge ctl_clk);
        aux_sel = 1'b1;
        track(0, "R7 aux select change no effect");
        chk(sel_status == 3'b001, "R7 status unchanged", 32'(sel_status), 1);
        request(3'b100);
        wait_done("R7 switch to retuned aux");
        track(3, "R7 follows aux1");

        // R6: request changes during a handover
        request(3'b010);
        request(3'b001);
        wait_done("R6 held request completes");
        track(0, "R6 follows final request ref0");

        // R8: malformed requests ignored
        @(negedge ctl_clk);
        sel_req = 3'b011;
        repeat (10) @(negedge ctl_clk);
        #1;
        chk(sel_status == 3'b001, "R8 two-bit request ignored", 32'(sel_status), 1);
        sel_req = 3'b000;
        repeat (10) @(negedge ctl_clk);
        #1;
        chk(sel_status == 3'b001, "R8 zero request ignored", 32'(sel_status), 1);
        track(0, "R8 output unchanged");
        sel_req = 3'b001;
        repeat (4) @(negedge ctl_clk);

        chk(glitch_cnt == 0, "R2 short phases", 32'(glitch_cnt), 0);
        chk(max_gap < GAP_MAX, "R3 output gap ns", 32'(int'(max_gap)), 32'(int'(GAP_MAX)));
        chk(exp_q.size() == 0, "R6 pending expectations", 32'(exp_q.size()), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule